// File: doc/BRIEF.md
# Debug Core Register Transfer Engine

This block lets a debugger move one processor register at a time between the core and a 32-bit data buffer. The debugger loads the buffer through its own write strobe, then issues a selector word. The selector carries a 7-bit register number and a direction flag. While the core is halted, the engine decides whether the chosen register exists and may be touched. If it may, the engine runs one request/acknowledge exchange with the core register file port and drops its ready flag until the acknowledge arrives.

Register numbers that are undefined, or that belong to an absent or forbidden feature, take no part in the exchange. A read of one of them loads zero into the buffer, and a write to one of them is discarded. Secure-only entries need both the security feature and the secure-debug permission input. Floating-point entries need the floating-point feature and a clear access-denied input. A completed read always replaces the buffer contents. The buffer itself has no reset.

Top module: `dxe_top`

## Requirements
- R1: After reset, `ready` is 1 and `rf_req` is 0.
- R2: A selector write that is accepted, with the core halted, the engine idle and the register accessible, drives `ready` to 0 and `rf_req` to 1 from the next cycle. `rf_idx` equals selector bits 6:0 and `rf_we` equals selector bit 16 (1 = write core register from buffer, 0 = read into buffer). Both hold steady until the acknowledge.
- R3: The clock edge at which `rf_ack` is 1 during a request ends the transfer. From the next cycle `ready` is 1 and `rf_req` is 0.
- R4: A read transfer loads `rf_rdata`, sampled at the acknowledge edge, into the buffer. This replaces any value the debugger wrote earlier.
- R5: During a write transfer, `rf_wdata` equals the buffer, and the buffer keeps its value.
- R6: A selector write while `halted` is 0 is ignored: no request is made, `ready` stays 1 and the buffer is unchanged.
- R7: Accessible numbers are 0x00 to 0x12, 0x14, 0x1E, 0x1F, and the conditional groups of R8 to R10. Every other number is reserved. A reserved read makes no request, keeps `ready` at 1 and loads 0 into the buffer one cycle later. A reserved write makes no request and leaves the buffer unchanged.
- R8: Numbers 0x1A to 0x1D are accessible only when `sec_present` and `sec_dbg_ok` are both 1. Otherwise they behave as in R7.
- R9: Numbers 0x21 and 0x40 to 0x5F are accessible only when `fp_present` is 1 and `fp_denied` is 0. Otherwise they behave as in R7.
- R10: Numbers 0x18 and 0x19 are accessible only when `sec_present` is 1. Otherwise they behave as in R7.
- R11: A selector write while a transfer is in progress is ignored. `rf_idx` and `rf_we` keep the values of the running transfer.
- R12: A debugger buffer write appears on `buf_rdata` in the next cycle. When it coincides with the acknowledge of a read transfer, the read data wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Debugger writes the selector word this cycle |
| sel_wdata | input | 32 | Selector word: bit 16 direction, bits 6:0 register number |
| buf_wr | input | 1 | Debugger writes the data buffer this cycle |
| buf_wdata | input | 32 | Data written into the buffer |
| buf_rdata | output | 32 | Current buffer contents |
| ready | output | 1 | 1 when no transfer is in progress |
| halted | input | 1 | Core is halted; transfers are accepted only then |
| sec_present | input | 1 | Security feature implemented |
| sec_dbg_ok | input | 1 | Secure debug permitted |
| fp_present | input | 1 | Floating-point feature implemented |
| fp_denied | input | 1 | Floating-point registers currently not accessible |
| rf_req | output | 1 | Request to the core register file port |
| rf_we | output | 1 | Request direction, 1 = write |
| rf_idx | output | 7 | Register number of the request |
| rf_wdata | output | 32 | Write data for the register file |
| rf_ack | input | 1 | Register file acknowledge |
| rf_rdata | input | 32 | Register file read data, valid with `rf_ack` |

## Verification
A bad accessibility decode shows up one cycle after the selector write. Either `ready` drops for a register that should read as zero, or a request with the wrong number appears, and on a read the buffer then holds the wrong value. A control state stuck busy holds `ready` low past the acknowledge, which shows on the next sample. Lost selector fields appear on `rf_idx` or `rf_we` for the whole request. The bench sweeps every one of the 128 register numbers under all sixteen feature and permission combinations and compares against an independent map.

// File: rtl/dxe_pkg.sv
package dxe_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned IDX_W   = 7;
  localparam int unsigned DIR_BIT = 16;

  typedef enum logic [0:0] {
    XS_IDLE = 1'b0,
    XS_BUSY = 1'b1
  } xfer_state_e;

  typedef enum logic [2:0] {
    RG_PLAIN   = 3'd0,
    RG_NS_BANK = 3'd1,
    RG_SECURE  = 3'd2,
    RG_FLOAT   = 3'd3,
    RG_NONE    = 3'd4
  } reg_group_e;

  typedef struct packed {
    logic                 dir_wr;
    logic [IDX_W-1:0]     idx;
  } sel_fields_t;
endpackage

// File: rtl/dxe_sel_decode.sv
module dxe_sel_decode
  import dxe_pkg::*;
#(
  parameter int unsigned IW = IDX_W
) (
  input  logic [IW-1:0] idx,
  input  logic          sec_present,
  input  logic          sec_dbg_ok,
  input  logic          fp_present,
  input  logic          fp_denied,
  output reg_group_e    group,
  output logic          accessible
);
  localparam int unsigned FP_BASE  = 64;
  localparam int unsigned FP_COUNT = 32;

  logic in_fp_bank;

  always_comb begin
    in_fp_bank = (32'(idx) >= FP_BASE) && (32'(idx) < FP_BASE + FP_COUNT);
    if (32'(idx) <= 32'h12 || 32'(idx) == 32'h14 ||
        32'(idx) == 32'h1E || 32'(idx) == 32'h1F) begin
      group = RG_PLAIN;
    end else if (32'(idx) == 32'h18 || 32'(idx) == 32'h19) begin
      group = RG_NS_BANK;
    end else if (32'(idx) >= 32'h1A && 32'(idx) <= 32'h1D) begin
      group = RG_SECURE;
    end else if (32'(idx) == 32'h21 || in_fp_bank) begin
      group = RG_FLOAT;
    end else begin
      group = RG_NONE;
    end
  end

  always_comb begin
    unique case (group)
      RG_PLAIN:   accessible = 1'b1;
      RG_NS_BANK: accessible = sec_present;
      RG_SECURE:  accessible = sec_present & sec_dbg_ok;
      RG_FLOAT:   accessible = fp_present & ~fp_denied;
      default:    accessible = 1'b0;
    endcase
  end

  always_comb begin
    assert_none_not_acc_R7: assert (!(group == RG_NONE && accessible));
  end
endmodule

// File: rtl/dxe_xfer_ctrl.sv
module dxe_xfer_ctrl
  import dxe_pkg::*;
#(
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_wr,
  input  sel_fields_t   sel_in,
  input  logic          halted,
  input  logic          accessible,
  input  logic          rf_ack,
  output logic          busy,
  output logic          rf_req,
  output logic          rf_we,
  output logic [IW-1:0] rf_idx,
  output logic          load_rd,
  output logic          load_zero
);
  xfer_state_e state_q, state_d;
  sel_fields_t sel_q, sel_d;
  logic        sel_en;
  logic        accept;

  always_comb begin
    accept    = sel_wr & halted & (state_q == XS_IDLE);
    state_d   = state_q;
    sel_d     = sel_q;
    sel_en    = 1'b0;
    load_rd   = 1'b0;
    load_zero = 1'b0;
    unique case (state_q)
      XS_IDLE: begin
        if (accept) begin
          if (accessible) begin
            state_d = XS_BUSY;
            sel_d   = sel_in;
            sel_en  = 1'b1;
          end else begin
            load_zero = ~sel_in.dir_wr;
          end
        end
      end
      XS_BUSY: begin
        if (rf_ack) begin
          state_d = XS_IDLE;
          load_rd = ~sel_q.dir_wr;
        end
      end
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign busy   = (state_q == XS_BUSY);
  assign rf_req = busy;
  assign rf_we  = sel_q.dir_wr;
  assign rf_idx = sel_q.idx;

  assert_sel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req && !rf_ack) |=> ($stable(rf_idx) && $stable(rf_we)));
  assert_ack_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req && rf_ack) |=> !rf_req);
  assert_no_start_unhalted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rf_req && !halted) |=> !rf_req);
  assert_start_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rf_req && sel_wr && halted && accessible) |=>
      (rf_req && rf_idx == $past(sel_in.idx) && rf_we == $past(sel_in.dir_wr)));
endmodule

// File: rtl/dxe_data_buf.sv
module dxe_data_buf
  import dxe_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          load_rd,
  input  logic [DW-1:0] rd_data,
  input  logic          load_zero,
  input  logic          dbg_wr,
  input  logic [DW-1:0] dbg_data,
  output logic [DW-1:0] q
);
  logic [DW-1:0] d;
  logic          en;

  always_comb begin
    en = load_rd | load_zero | dbg_wr;
    if (load_rd)        d = rd_data;
    else if (load_zero) d = '0;
    else                d = dbg_data;
  end

  always_ff @(posedge clk) begin
    if (en) q <= d;
  end

  assert_rd_wins_R12: assert property (@(posedge clk)
    load_rd |=> (q == $past(rd_data)));
  assert_raz_R7: assert property (@(posedge clk)
    (load_zero && !load_rd) |=> (q == '0));
endmodule

// File: rtl/dxe_top.sv
module dxe_top
  import dxe_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IDX_W,
  parameter int unsigned DB = DIR_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_wr,
  input  logic [DW-1:0] sel_wdata,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_wdata,
  output logic [DW-1:0] buf_rdata,
  output logic          ready,
  input  logic          halted,
  input  logic          sec_present,
  input  logic          sec_dbg_ok,
  input  logic          fp_present,
  input  logic          fp_denied,
  output logic          rf_req,
  output logic          rf_we,
  output logic [IW-1:0] rf_idx,
  output logic [DW-1:0] rf_wdata,
  input  logic          rf_ack,
  input  logic [DW-1:0] rf_rdata
);
  sel_fields_t sel_in;
  reg_group_e  group;
  logic        accessible;
  logic        busy;
  logic        load_rd;
  logic        load_zero;

  assign sel_in.dir_wr = sel_wdata[DB];
  assign sel_in.idx    = sel_wdata[IW-1:0];

  dxe_sel_decode #(.IW(IW)) u_dec (
    .idx         (sel_in.idx),
    .sec_present (sec_present),
    .sec_dbg_ok  (sec_dbg_ok),
    .fp_present  (fp_present),
    .fp_denied   (fp_denied),
    .group       (group),
    .accessible  (accessible)
  );

  dxe_xfer_ctrl #(.IW(IW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_wr     (sel_wr),
    .sel_in     (sel_in),
    .halted     (halted),
    .accessible (accessible),
    .rf_ack     (rf_ack),
    .busy       (busy),
    .rf_req     (rf_req),
    .rf_we      (rf_we),
    .rf_idx     (rf_idx),
    .load_rd    (load_rd),
    .load_zero  (load_zero)
  );

  dxe_data_buf #(.DW(DW)) u_buf (
    .clk       (clk),
    .load_rd   (load_rd),
    .rd_data   (rf_rdata),
    .load_zero (load_zero),
    .dbg_wr    (buf_wr),
    .dbg_data  (buf_wdata),
    .q         (buf_rdata)
  );

  assign ready    = ~busy;
  assign rf_wdata = buf_rdata;

  assert_req_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req |-> !ready);
  assert_ready_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req && rf_ack) |=> ready);
  assert_wr_keeps_buf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req && rf_we && !buf_wr) |=> $stable(buf_rdata));
  assert_reserved_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && sel_wr && !accessible) |=> ready);
endmodule

// File: tb/tb_dxe_top.sv
module tb_dxe_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_wr = 1'b0;
  logic [31:0] sel_wdata = '0;
  logic        buf_wr = 1'b0;
  logic [31:0] buf_wdata = '0;
  logic [31:0] buf_rdata;
  logic        ready;
  logic        halted = 1'b1;
  logic        sec_present = 1'b0, sec_dbg_ok = 1'b0, fp_present = 1'b0, fp_denied = 1'b0;
  logic        rf_req, rf_we;
  logic [6:0]  rf_idx;
  logic [31:0] rf_wdata;
  logic        rf_ack = 1'b0;
  logic [31:0] rf_rdata = '0;

  int checks = 0;
  int fails = 0;
  bit auto_ack = 1'b1;
  int ack_cnt = 0;
  bit seen_req;
  bit seen_we;
  logic [6:0]  seen_idx;
  logic [31:0] seen_wdata;

  always #10 clk = ~clk;

  dxe_top dut (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .ready(ready),
    .halted(halted), .sec_present(sec_present), .sec_dbg_ok(sec_dbg_ok),
    .fp_present(fp_present), .fp_denied(fp_denied), .rf_req(rf_req), .rf_we(rf_we),
    .rf_idx(rf_idx), .rf_wdata(rf_wdata), .rf_ack(rf_ack), .rf_rdata(rf_rdata)
  );

  function automatic logic [31:0] core_val(input logic [6:0] i);
    return 32'hC300_0000 | (32'(i) << 8) | 32'(~i & 7'h7F);
  endfunction

  function automatic bit exp_acc(input int i, input bit se, input bit so, input bit fp, input bit fd);
    if (i <= 18 || i == 20 || i == 30 || i == 31) return 1'b1;
    if (i == 24 || i == 25) return se;
    if (i >= 26 && i <= 29) return se && so;
    if (i == 33 || (i >= 64 && i <= 95)) return fp && !fd;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // register file responder: acknowledges after two cycles of request
  always @(negedge clk) begin
    if (auto_ack) begin
      if (rf_req && !rf_ack) begin
        seen_req   <= 1'b1;
        seen_we    <= rf_we;
        seen_idx   <= rf_idx;
        seen_wdata <= rf_wdata;
        ack_cnt = ack_cnt + 1;
        if (ack_cnt == 2) begin
          rf_ack   <= 1'b1;
          rf_rdata <= core_val(rf_idx);
        end
      end else begin
        rf_ack  <= 1'b0;
        ack_cnt = 0;
      end
    end
  end

  task automatic buf_load(input logic [31:0] v);
    @(negedge clk);
    buf_wr = 1'b1; buf_wdata = v;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic xfer(input int i, input bit wr, input bit acc);
    logic [31:0] pat;
    pat = 32'h5EED_0000 | 32'(i);
    buf_load(pat);
    seen_req = 1'b0;
    sel_wr = 1'b1; sel_wdata = (32'(wr) << 16) | 32'(i);
    @(negedge clk);
    sel_wr = 1'b0;
    check(ready == !acc, acc ? "R2" : "R7", 32'(ready), 32'(!acc));
    for (int k = 0; k < 12 && !ready; k++) @(negedge clk);
    check(ready === 1'b1 && rf_req === 1'b0, "R3", 32'(ready), 32'h1);
    check(seen_req == acc, acc ? "R2" : "R8 R9 R10", 32'(seen_req), 32'(acc));
    if (acc) check(seen_idx == 7'(i) && seen_we == wr, "R2", {24'h0, seen_we, seen_idx},
                   {24'h0, wr, 7'(i)});
    if (wr) begin
      check(buf_rdata == pat, "R5", buf_rdata, pat);
      if (acc) check(seen_wdata == pat, "R5", seen_wdata, pat);
    end else begin
      check(buf_rdata == (acc ? core_val(7'(i)) : 32'h0), acc ? "R4" : "R7",
            buf_rdata, acc ? core_val(7'(i)) : 32'h0);
    end
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ready === 1'b1 && rf_req === 1'b0, "R1", {30'h0, ready, rf_req}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready === 1'b1 && rf_req === 1'b0, "R1", {30'h0, ready, rf_req}, 32'h2);

    // R7 R8 R9 R10: every number under every feature/permission combination, reads
    for (int c = 0; c < 16; c++) begin
      {sec_present, sec_dbg_ok, fp_present, fp_denied} = 4'(c);
      for (int i = 0; i < 128; i++)
        xfer(i, 1'b0, exp_acc(i, c[3], c[2], c[1], c[0]));
    end
    // R5: writes over the numbers under two configurations
    for (int c = 0; c < 2; c++) begin
      {sec_present, sec_dbg_ok, fp_present, fp_denied} = c ? 4'b1110 : 4'b0001;
      for (int i = 0; i < 128; i++)
        xfer(i, 1'b1, exp_acc(i, c[0], c[0], c[0], !c[0]));
    end

    // R6: not halted
    {sec_present, sec_dbg_ok, fp_present, fp_denied} = 4'b1110;
    buf_load(32'h1234_5678);
    halted = 1'b0;
    seen_req = 1'b0;
    sel_wr = 1'b1; sel_wdata = 32'h0000_0003;
    @(negedge clk);
    sel_wr = 1'b0;
    check(ready === 1'b1, "R6", 32'(ready), 32'h1);
    repeat (4) @(negedge clk);
    check(!seen_req && buf_rdata == 32'h1234_5678, "R6", buf_rdata, 32'h1234_5678);
    halted = 1'b1;

    // R11 and R12: manual acknowledge
    auto_ack = 1'b0;
    rf_ack = 1'b0;
    sel_wr = 1'b1; sel_wdata = 32'h0000_0005;
    @(negedge clk);
    sel_wdata = 32'h0001_0007;
    @(negedge clk);
    sel_wr = 1'b0;
    check(rf_req && rf_idx == 7'd5 && !rf_we, "R11", {24'h0, rf_we, rf_idx}, 32'h5);
    rf_ack = 1'b1; rf_rdata = 32'hFACE_0005;
    buf_wr = 1'b1; buf_wdata = 32'h0BAD_0BAD;
    @(negedge clk);
    rf_ack = 1'b0; buf_wr = 1'b0;
    check(buf_rdata == 32'hFACE_0005, "R12", buf_rdata, 32'hFACE_0005);
    check(ready === 1'b1, "R3", 32'(ready), 32'h1);
    buf_wr = 1'b1; buf_wdata = 32'h7777_1111;
    @(negedge clk);
    buf_wr = 1'b0;
    check(buf_rdata == 32'h7777_1111, "R12", buf_rdata, 32'h7777_1111);
    auto_ack = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule